// File: doc/BRIEF.md
# Vector Floating-Point Reciprocal Exponent Unit

This block produces a coarse reciprocal estimate for IEEE-754 operands held in a 128-bit vector register: every active lane keeps its sign, takes the bitwise complement of its exponent field and drops its fraction. The result approximates 1/x to within a power of two. It is used as a cheap scaling step ahead of iterative division or normalisation sequences. Operands are single precision (32-bit lanes) or double precision (64-bit lanes), processed as one scalar element or as a packed vector.

NaN operands are propagated. A signaling NaN comes back quieted and raises a sticky invalid-operation flag. A mode bit replaces every NaN result with the canonical default NaN. Lanes that the selected shape does not use are written as zero. The result and its valid strobe are registered, so each result appears one cycle after its input.

Top module: `frecpx_vec`

## Requirements
- R1: For a non-NaN lane the result keeps the sign bit, holds the bitwise complement of the input exponent in the exponent field, and has an all-zero fraction. Single lanes use sign bit 31, exponent bits 30:23 and fraction bits 22:0. Double lanes use sign bit 63, exponent bits 62:52 and fraction bits 51:0.
- R2: A lane whose exponent field is zero (a zero or a subnormal) gets exponent 0xFE (single) or 0x7FE (double), not all ones.
- R3: An infinity (exponent all ones, fraction zero) returns a zero that carries the input's sign.
- R4: A signaling NaN (exponent all ones, fraction nonzero, fraction MSB clear) is returned with the fraction MSB set and sets the invalid flag.
- R5: A quiet NaN (exponent all ones, fraction MSB set) is returned unchanged and does not set the invalid flag.
- R6: With default-NaN mode on, every NaN lane returns 0x7FC00000 (single) or 0x7FF8000000000000 (double). A signaling NaN still sets the invalid flag in this mode.
- R7: In single-precision vector mode, full width processes four lanes. Half width processes lanes 0 and 1 and clears bits 127:64 of the result.
- R8: In double-precision vector mode both 64-bit lanes are processed, whatever the full-width select holds.
- R9: In scalar mode only lane 0 is processed. All result bits above lane 0 are zero, and a signaling NaN in any other lane does not set the invalid flag.
- R10: out_valid follows in_valid one cycle later. The result register loads only on a cycle with in_valid high and holds its value otherwise.
- R11: The invalid flag stays set until inv_clr is high on a clock edge. On an edge where a new signaling NaN is accepted at the same time as a clear, the flag is set.
- R12: After reset, out_vec, out_valid and inv_flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_vec | input | 128 | Operand vector |
| dbl_sel | input | 1 | 1: double-precision lanes, 0: single-precision lanes |
| scalar_sel | input | 1 | 1: scalar (lane 0 only), 0: packed vector |
| full_sel | input | 1 | Single-precision vector width: 1 = four lanes, 0 = two lanes |
| dnan_en | input | 1 | Default-NaN mode |
| inv_clr | input | 1 | Clears the sticky invalid flag |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_vec | output | 128 | Result vector |
| inv_flag | output | 1 | Sticky invalid-operation flag |

## Verification
Every result of this block is due on the first rising edge after the operand is presented: out_vec, out_valid and any change of inv_flag caused by an accepted signaling NaN or by a clear. The bench drives each cycle's inputs on the falling edge and updates its behavioural model at the same moment. On the next falling edge it compares all three outputs against the model, so each comparison lands exactly one register stage after its stimulus. Idle cycles are compared in the same way, which checks that the result holds and that the flag persists.

// File: rtl/frx_pkg.sv
// Shared constants for the reciprocal exponent unit.
// Assumes a vector width that is a multiple of 64 bits.
package frx_pkg;
    localparam int VEC_W    = 128;
    localparam int SP_EW    = 8;
    localparam int SP_FW    = 23;
    localparam int DP_EW    = 11;
    localparam int DP_FW    = 52;
    localparam int SP_W     = SP_EW + SP_FW + 1;
    localparam int DP_W     = DP_EW + DP_FW + 1;
    localparam int SP_LANES = VEC_W / SP_W;
    localparam int DP_LANES = VEC_W / DP_W;

    // Operating shape captured per request
    typedef struct packed {
        logic dbl;
        logic scalar;
        logic full;
        logic dnan;
    } frx_mode_t;
endpackage

// File: rtl/frx_lane.sv
// One reciprocal-exponent lane for a generic IEEE-754 format.
// Purely combinational; EW/FW select the exponent and fraction widths.
// Assumes FW >= 2 so that a quiet bit and payload both exist.
module frx_lane #(
    parameter int EW = 8,
    parameter int FW = 23
) (
    input  logic [EW+FW:0] op,
    input  logic           dnan_en,
    output logic [EW+FW:0] res,
    output logic           is_snan
);
    localparam int W = EW + FW + 1;
    localparam logic [W-1:0]  DEF_NAN  = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};
    localparam logic [W-1:0]  QBIT     = W'(1) << (FW - 1);
    localparam logic [EW-1:0] ZERO_EXP = {{(EW-1){1'b1}}, 1'b0};

    logic          sgn;
    logic [EW-1:0] expo;
    logic [FW-1:0] frac;
    logic          is_nan;

    // Field split and NaN classification
    always_comb begin
        sgn     = op[W-1];
        expo    = op[W-2:FW];
        frac    = op[FW-1:0];
        is_nan  = (&expo) && (|frac);
        is_snan = is_nan && !frac[FW-1];
    end

    // Result selection: NaN handling or complemented exponent
    always_comb begin
        if (is_nan) begin
            res = dnan_en ? DEF_NAN : (op | QBIT);
        end else if (expo == '0) begin
            res = {sgn, ZERO_EXP, {FW{1'b0}}};
        end else begin
            res = {sgn, ~expo, {FW{1'b0}}};
        end
    end
endmodule

// File: rtl/frx_lane_mask.sv
// Decodes the operating shape into per-lane enables for both precisions.
// Assumes an even number of single lanes; half width uses the lower half.
module frx_lane_mask #(
    parameter int SPL = 4,
    parameter int DPL = 2
) (
    input  logic           dbl,
    input  logic           scalar,
    input  logic           full,
    output logic [SPL-1:0] sp_act,
    output logic [DPL-1:0] dp_act
);
    localparam int SP_HALF = SPL / 2;

    // Single-precision lane enables
    always_comb begin
        for (int i = 0; i < SPL; i++) begin
            if (scalar) sp_act[i] = !dbl && (i == 0);
            else        sp_act[i] = !dbl && (full || (i < SP_HALF));
        end
    end

    // Double-precision lane enables
    always_comb begin
        for (int i = 0; i < DPL; i++) begin
            dp_act[i] = dbl && (!scalar || (i == 0));
        end
    end
endmodule

// File: rtl/frx_flag.sv
// Sticky flag: set has priority over clear; synchronous active-low reset.
module frx_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold, set or clear the sticky bit
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/frecpx_vec.sv
// Vector reciprocal exponent unit. Splits a 128-bit register into single or
// double lanes, computes each lane, zeroes unused lanes and registers the
// result with one cycle of latency. Assumes inputs are stable at the edge.
module frecpx_vec
    import frx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] in_vec,
    input  logic             dbl_sel,
    input  logic             scalar_sel,
    input  logic             full_sel,
    input  logic             dnan_en,
    input  logic             inv_clr,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vec,
    output logic             inv_flag
);
    frx_mode_t            mode;
    logic [SP_LANES-1:0]  sp_act, sp_snan;
    logic [DP_LANES-1:0]  dp_act, dp_snan;
    logic [SP_W-1:0]      sp_res [SP_LANES];
    logic [DP_W-1:0]      dp_res [DP_LANES];
    logic [VEC_W-1:0]     sp_vec, dp_vec, nxt_vec;
    logic                 snan_hit;

    // Bundle the mode inputs
    always_comb begin
        mode = '{dbl: dbl_sel, scalar: scalar_sel, full: full_sel, dnan: dnan_en};
    end

    frx_lane_mask #(.SPL(SP_LANES), .DPL(DP_LANES)) u_mask (
        .dbl    (mode.dbl),
        .scalar (mode.scalar),
        .full   (mode.full),
        .sp_act (sp_act),
        .dp_act (dp_act)
    );

    for (genvar g = 0; g < SP_LANES; g++) begin : g_sp
        frx_lane #(.EW(SP_EW), .FW(SP_FW)) u_lane (
            .op      (in_vec[g*SP_W +: SP_W]),
            .dnan_en (mode.dnan),
            .res     (sp_res[g]),
            .is_snan (sp_snan[g])
        );
    end

    for (genvar g = 0; g < DP_LANES; g++) begin : g_dp
        frx_lane #(.EW(DP_EW), .FW(DP_FW)) u_lane (
            .op      (in_vec[g*DP_W +: DP_W]),
            .dnan_en (mode.dnan),
            .res     (dp_res[g]),
            .is_snan (dp_snan[g])
        );
    end

    // Assemble lane results, zeroing inactive lanes
    always_comb begin
        sp_vec = '0;
        dp_vec = '0;
        for (int i = 0; i < SP_LANES; i++)
            if (sp_act[i]) sp_vec[i*SP_W +: SP_W] = sp_res[i];
        for (int i = 0; i < DP_LANES; i++)
            if (dp_act[i]) dp_vec[i*DP_W +: DP_W] = dp_res[i];
        nxt_vec  = mode.dbl ? dp_vec : sp_vec;
        snan_hit = in_valid && ((|(sp_snan & sp_act)) || (|(dp_snan & dp_act)));
    end

    // Output register: load on valid, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vec   <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_vec <= nxt_vec;
        end
    end

    frx_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (snan_hit),
        .clr   (inv_clr),
        .flag  (inv_flag)
    );
endmodule

// File: rtl/frx_chk.sv
// Protocol and shape checks for frecpx_vec, bound to every instance.
module frx_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [127:0] in_vec,
    input logic         dbl_sel,
    input logic         scalar_sel,
    input logic         full_sel,
    input logic         inv_clr,
    input logic         out_valid,
    input logic [127:0] out_vec,
    input logic         inv_flag
);
    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R10
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R10
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_vec));
    // R11
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_flag && !inv_clr) |=> inv_flag);
    // R11
    clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_clr && !in_valid) |=> !inv_flag);
    // R9
    scalar_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && scalar_sel) |=> (out_vec[127:64] == '0));
    // R7
    half_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !scalar_sel && !dbl_sel && !full_sel) |=> (out_vec[127:64] == '0));
    // R1
    dp_frac_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dbl_sel && (in_vec[62:52] != 11'h7FF)) |=> (out_vec[51:0] == '0));
endmodule

bind frecpx_vec frx_chk u_frx_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_vec     (in_vec),
    .dbl_sel    (dbl_sel),
    .scalar_sel (scalar_sel),
    .full_sel   (full_sel),
    .inv_clr    (inv_clr),
    .out_valid  (out_valid),
    .out_vec    (out_vec),
    .inv_flag   (inv_flag)
);

// File: tb/tb_frecpx_vec.sv
module tb_frecpx_vec;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_vec = '0;
    logic         dbl_sel = 1'b0, scalar_sel = 1'b0, full_sel = 1'b0;
    logic         dnan_en = 1'b0, inv_clr = 1'b0;
    logic         out_valid;
    logic [127:0] out_vec;
    logic         inv_flag;

    int n_tests = 0;
    int n_fail  = 0;

    logic [127:0] m_vec = '0;
    logic         m_valid = 1'b0;
    logic         m_inv = 1'b0;
    string        m_tag = "R12";

    always #2 clk = ~clk;

    frecpx_vec dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
        .dbl_sel(dbl_sel), .scalar_sel(scalar_sel), .full_sel(full_sel),
        .dnan_en(dnan_en), .inv_clr(inv_clr),
        .out_valid(out_valid), .out_vec(out_vec), .inv_flag(inv_flag)
    );

    // Behavioural reference: lane count from mode, IEEE field rules per lane
    function automatic void ref_model(input logic [127:0] v, input logic dbl,
                                      input logic sc, input logic full, input logic dn,
                                      output logic [127:0] r, output logic inv);
        int n;
        r = '0;
        inv = 1'b0;
        if (sc)       n = 1;
        else if (dbl) n = 2;
        else          n = full ? 4 : 2;
        for (int i = 0; i < n; i++) begin
            if (dbl) begin
                logic [63:0] op;
                logic [63:0] rr;
                op = v[64*i +: 64];
                if (op[62:52] == 11'h7FF && op[51:0] != 0) begin
                    if (!op[51]) inv = 1'b1;
                    rr = dn ? 64'h7FF8000000000000 : (op | 64'h0008000000000000);
                end else if (op[62:52] == 0) begin
                    rr = {op[63], 11'h7FE, 52'h0};
                end else begin
                    rr = {op[63], 11'h7FF - op[62:52], 52'h0};
                end
                r[64*i +: 64] = rr;
            end else begin
                logic [31:0] op;
                logic [31:0] rr;
                op = v[32*i +: 32];
                if (op[30:23] == 8'hFF && op[22:0] != 0) begin
                    if (!op[22]) inv = 1'b1;
                    rr = dn ? 32'h7FC00000 : (op | 32'h00400000);
                end else if (op[30:23] == 0) begin
                    rr = {op[31], 8'hFE, 23'h0};
                end else begin
                    rr = {op[31], 8'hFF - op[30:23], 23'h0};
                end
                r[32*i +: 32] = rr;
            end
        end
    endfunction

    task automatic compare();
        n_tests++;
        if (out_vec !== m_vec) begin
            n_fail++;
            $display("FAIL %s out_vec actual=%h expected=%h", m_tag, out_vec, m_vec);
        end
        n_tests++;
        if (out_valid !== m_valid) begin
            n_fail++;
            $display("FAIL %s out_valid actual=%b expected=%b", m_tag, out_valid, m_valid);
        end
        n_tests++;
        if (inv_flag !== m_inv) begin
            n_fail++;
            $display("FAIL %s inv_flag actual=%b expected=%b", m_tag, inv_flag, m_inv);
        end
    endtask

    // One clock: check last cycle's outputs, advance model, drive new inputs
    task automatic cyc(input logic v, input logic [127:0] d, input logic dbl,
                       input logic sc, input logic full, input logic dn,
                       input logic clr, input string tag);
        logic [127:0] r;
        logic         inv;
        @(negedge clk);
        compare();
        ref_model(d, dbl, sc, full, dn, r, inv);
        if (v) m_vec = r;
        m_valid = v;
        m_inv   = (v && inv) ? 1'b1 : (clr ? 1'b0 : m_inv);
        m_tag   = tag;
        in_valid = v; in_vec = d; dbl_sel = dbl; scalar_sel = sc;
        full_sel = full; dnan_en = dn; inv_clr = clr;
    endtask

    task automatic idle(input string tag);
        cyc(1'b0, 128'hDEADBEEF_DEADBEEF_DEADBEEF_DEADBEEF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare();                 // R12 reset state
        rst_n = 1'b1;
        // R1 single full vector of normals
        cyc(1, 128'h3F800000_C0400000_7F7FFFFF_00800000, 0, 0, 1, 0, 0, "R1");
        // R2 zeros and subnormals
        cyc(1, 128'h00000000_80000000_00000001_807FFFFF, 0, 0, 1, 0, 0, "R2");
        cyc(1, 128'h80000000_00000000_000FFFFF_FFFFFFFF, 1, 0, 0, 0, 0, "R2");
        // R3 infinities
        cyc(1, 128'h7F800000_FF800000_7F800000_FF800000, 0, 0, 1, 0, 0, "R3");
        cyc(1, 128'hFFF00000_00000000_7FF00000_00000000, 1, 0, 1, 0, 0, "R3");
        // R5 quiet NaNs: unchanged, flag stays clear
        cyc(1, 128'h7FC00001_FFFFFFFF_7FF80000_00000005, 0, 0, 1, 0, 0, "R5");
        cyc(1, 128'h7FF80000_0000ABCD_FFF80000_00000000, 1, 0, 0, 0, 0, "R5");
        // R4 signaling NaN sets flag and is quieted
        cyc(1, 128'h3F800000_3F800000_3F800000_7F800001, 0, 0, 1, 0, 0, "R4");
        // R11 flag persists over idle cycles
        idle("R11");
        idle("R10");
        // R11 clear
        cyc(0, '0, 0, 0, 0, 0, 1, "R11");
        idle("R11");
        // R4 double signaling NaN
        cyc(1, 128'h3FF00000_00000000_7FF00000_00000001, 1, 0, 1, 0, 0, "R4");
        // R11 set and clear on the same edge: set wins
        cyc(1, 128'h0_0_0_FF800010, 0, 0, 1, 0, 1, "R11");
        cyc(0, '0, 0, 0, 0, 0, 1, "R11");
        // R6 default NaN mode, single and double
        cyc(1, 128'h7FC12345_FF800001_3F800000_7FA00000, 0, 0, 1, 1, 0, "R6");
        cyc(0, '0, 0, 0, 0, 0, 1, "R6");
        cyc(1, 128'hFFF80000_00000001_7FF00000_00000002, 1, 0, 0, 1, 0, "R6");
        cyc(0, '0, 0, 0, 0, 0, 1, "R6");
        // R7 half width single: upper 64 cleared, sNaN there ignored
        cyc(1, 128'h7F800001_3F800000_40000000_C1200000, 0, 0, 0, 0, 0, "R7");
        // R8 double vector ignores full select
        cyc(1, 128'h40000000_00000000_BFF00000_00000000, 1, 0, 0, 0, 0, "R8");
        cyc(1, 128'h40000000_00000000_BFF00000_00000000, 1, 0, 1, 0, 0, "R8");
        // R9 scalar single and double: only lane 0
        cyc(1, 128'h7F800001_7F800001_7F800001_3F800000, 0, 1, 1, 0, 0, "R9");
        cyc(1, 128'h7FF00000_00000001_C0000000_00000000, 1, 1, 1, 0, 0, "R9");
        // R10 back-to-back then idle hold
        cyc(1, 128'h11111111_22222222_33333333_44444444, 0, 0, 1, 0, 0, "R10");
        cyc(1, 128'h55555555_66666666_77777777_08888888, 0, 0, 1, 0, 0, "R10");
        idle("R10");
        idle("R10");
        // R12 synchronous reset returns to zero
        @(negedge clk);
        compare();
        rst_n = 1'b0;
        m_vec = '0; m_valid = 1'b0; m_inv = 1'b0; m_tag = "R12";
        @(negedge clk);
        compare();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule